// File: doc/BRIEF.md
# Fixed-Point Vector Outer Product Unit

This block is the arithmetic core of a geometry coprocessor command pair. On a start pulse it captures a three-lane signed 16-bit vector, the three diagonal entries of a 3x3 rotation matrix, and two mode bits. It then computes one lane per cycle. Each lane result goes to a 32-bit accumulator and to a clamped 16-bit copy. A status word reports clamping and holds a summary error bit.

Two commands are supported. The cross command computes the cross product of the vector with the diagonal treated as a vector. The square command computes the per-lane square of the vector. Either result may be scaled down by 12 fractional bits before it is stored.

The 16-bit results replace, in the surrounding register file, the very vector the command reads. For that reason every operand is captured in the accept cycle. The unit then ignores its data inputs until the command completes.

Top module: `vop_unit`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `busy`, `done`, `flags`, all three `mac` outputs and all three `ir_out` outputs read zero.
- R2: A start pulse with a supported opcode, seen while idle, raises `busy` from the next cycle for exactly four cycles. `done` is high for exactly one cycle, which is the first cycle in which `busy` is low again.
- R3: Opcode 0x0C (cross) sets the lane results as follows, with lanes numbered 1 to 3:
  - lane 1 = v3*d2 - v2*d3
  - lane 2 = v1*d3 - v3*d1
  - lane 3 = v2*d1 - v1*d2

  Each difference is computed exactly. When `shift_sel` is 1 it is then shifted right arithmetically by 12. The outcome is always representable in the 32-bit `mac` output.
- R4: Opcode 0x28 (square) sets lane n to vn*vn, shifted right by 12 when `shift_sel` is 1.
- R5: With `lim_mode` 0, each `ir_out` lane is its `mac` value clamped to -32768..32767.
- R6: With `lim_mode` 1, each `ir_out` lane is its `mac` value clamped to 0..32767.
- R7: `flags` bit n-1 (n = 1..3) is 1 when lane n was clamped. Bit 3 is the OR of bits 0..2. All four bits read zero from the cycle after a command is accepted. The summary bit is valid when `done` is high.
- R8: Vector, diagonal and mode inputs are sampled only in the accept cycle. Changing them while `busy` is high does not alter the results.
- R9: A start pulse while `busy` is high is ignored. It neither restarts nor extends the command.
- R10: A start pulse with any other opcode is ignored. `busy` stays low, and `done`, `flags` and all results keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle command request |
| opcode | input | 6 | Command code: 0x0C cross, 0x28 square |
| shift_sel | input | 1 | 1: scale results down by 12 bits |
| lim_mode | input | 1 | 1: clamp copies at zero from below |
| ir_in1 | input | 16 | Vector lane 1 (signed) |
| ir_in2 | input | 16 | Vector lane 2 (signed) |
| ir_in3 | input | 16 | Vector lane 3 (signed) |
| diag1 | input | 16 | Matrix diagonal entry 1 (signed) |
| diag2 | input | 16 | Matrix diagonal entry 2 (signed) |
| diag3 | input | 16 | Matrix diagonal entry 3 (signed) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mac1 | output | 32 | Lane 1 accumulator |
| mac2 | output | 32 | Lane 2 accumulator |
| mac3 | output | 32 | Lane 3 accumulator |
| ir_out1 | output | 16 | Lane 1 clamped copy |
| ir_out2 | output | 16 | Lane 2 clamped copy |
| ir_out3 | output | 16 | Lane 3 clamped copy |
| flags | output | 4 | Lane clamp bits [2:0], summary error [3] |

## Verification
The patterns below each separate a specific class of fault:
- Small mixed-sign operands with no scaling expose a swapped lane, a wrong index rotation or a sign error in the subtraction.
- Full-scale operands at -32768 drive the differences close to the 32-bit limits and force clamping. This separates a wrong clamp bound from a wrong flag lane.
- A case whose difference is -1 under scaling tells an arithmetic shift from a logical shift.
- Squares of -32768 and of small values check the second command against both clamp modes.
- Random runs mix in operand changes and extra start pulses during the busy window, along with an unsupported opcode. These expose missing operand capture and a handshake that can be retriggered.

// File: rtl/vop_pkg.sv
// Package: shared opcodes, scaling constant and sequencer state type for the
// outer product unit. Assumes a 6-bit command field.
package vop_pkg;
    localparam logic [5:0] OPC_CROSS  = 6'h0C;
    localparam logic [5:0] OPC_SQUARE = 6'h28;
    localparam int         FRAC_SHIFT = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LANE = 2'd1,
        ST_SUM  = 2'd2
    } vop_state_e;
endpackage

// File: rtl/vop_ctrl.sv
// Sequencer: accepts a command when idle, steps a lane index through every
// lane (one lane per cycle), then spends one cycle on the summary flag and
// emits a registered done pulse. Assumes opc_ok is valid with start.
module vop_ctrl
    import vop_pkg::*;
#(
    parameter int LANES = 3,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             opc_ok,
    output logic             accept,
    output logic             busy,
    output logic             lane_we,
    output logic             sum_we,
    output logic [IDX_W-1:0] lane_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

    vop_state_e state;

    // Decode handshake and write enables from the current state.
    always_comb begin
        accept  = start && opc_ok && (state == ST_IDLE);
        busy    = (state != ST_IDLE);
        lane_we = (state == ST_LANE);
        sum_we  = (state == ST_SUM);
    end

    // Advance the state, the lane counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lane_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= (state == ST_SUM);
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_LANE;
                        lane_idx <= '0;
                    end
                end
                ST_LANE: begin
                    if (lane_idx == LAST_LANE) begin
                        state    <= ST_SUM;
                        lane_idx <= '0;
                    end else begin
                        lane_idx <= lane_idx + 1'b1;
                    end
                end
                ST_SUM:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/vop_lane_math.sv
// Lane arithmetic: forms either a difference of two products (cross) or a
// square, exactly, then optionally shifts it right arithmetically. Purely
// combinational; assumes signed operands of W bits.
module vop_lane_math
    import vop_pkg::*;
#(
    parameter int W      = 16,
    parameter int PROD_W = 2 * W,
    parameter int DIFF_W = 2 * W + 1
) (
    input  logic                     sq,
    input  logic                     sh_en,
    input  logic signed [W-1:0]      ir_a,
    input  logic signed [W-1:0]      d_a,
    input  logic signed [W-1:0]      ir_b,
    input  logic signed [W-1:0]      d_b,
    input  logic signed [W-1:0]      ir_self,
    output logic signed [DIFF_W-1:0] full
);
    logic signed [PROD_W-1:0] prod_p;
    logic signed [PROD_W-1:0] prod_n;
    logic signed [DIFF_W-1:0] diff;

    // Select the positive and negative product terms for the command.
    always_comb begin
        if (sq) begin
            prod_p = PROD_W'(ir_self) * PROD_W'(ir_self);
            prod_n = '0;
        end else begin
            prod_p = PROD_W'(ir_a) * PROD_W'(d_a);
            prod_n = PROD_W'(ir_b) * PROD_W'(d_b);
        end
    end

    // Exact difference, one guard bit wider than a product, then scaling.
    always_comb begin
        diff = {prod_p[PROD_W-1], prod_p} - {prod_n[PROD_W-1], prod_n};
        full = sh_en ? (diff >>> FRAC_SHIFT) : diff;
    end
endmodule

// File: rtl/vop_clamp.sv
// Clamp: limits a wide signed value to a signed OUT_W range, or to the
// non-negative half of it when lm is set, and reports whether it clamped.
module vop_clamp #(
    parameter int IN_W  = 33,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0] val,
    input  logic                   lm,
    output logic [OUT_W-1:0]       out,
    output logic                   hit
);
    localparam logic signed [IN_W-1:0] HI     = IN_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [IN_W-1:0] LO_ALL = IN_W'(-(64'sd1 <<< (OUT_W - 1)));

    logic signed [IN_W-1:0] lo;

    // Compare against the mode-dependent bounds and pick the output.
    always_comb begin
        lo = lm ? '0 : LO_ALL;
        if (val > HI) begin
            out = HI[OUT_W-1:0];
            hit = 1'b1;
        end else if (val < lo) begin
            out = lo[OUT_W-1:0];
            hit = 1'b1;
        end else begin
            out = val[OUT_W-1:0];
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/vop_unit.sv
// Outer product unit top: captures vector, diagonal and modes on accept,
// computes one lane per cycle through a shared datapath, stores the
// accumulator and clamped copy per lane, then the summary error bit.
// Assumes start is a single-cycle pulse; inputs are ignored while busy.
module vop_unit
    import vop_pkg::*;
#(
    parameter int OPND_W = 16,
    parameter int MAC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [5:0]        opcode,
    input  logic              shift_sel,
    input  logic              lim_mode,
    input  logic [OPND_W-1:0] ir_in1,
    input  logic [OPND_W-1:0] ir_in2,
    input  logic [OPND_W-1:0] ir_in3,
    input  logic [OPND_W-1:0] diag1,
    input  logic [OPND_W-1:0] diag2,
    input  logic [OPND_W-1:0] diag3,
    output logic              busy,
    output logic              done,
    output logic [MAC_W-1:0]  mac1,
    output logic [MAC_W-1:0]  mac2,
    output logic [MAC_W-1:0]  mac3,
    output logic [OPND_W-1:0] ir_out1,
    output logic [OPND_W-1:0] ir_out2,
    output logic [OPND_W-1:0] ir_out3,
    output logic [3:0]        flags
);
    localparam int NUM_LANES = 3;
    localparam int IDX_W     = $clog2(NUM_LANES);
    localparam int DIFF_W    = 2 * OPND_W + 1;

    logic signed [OPND_W-1:0] ir_vec [NUM_LANES];
    logic signed [OPND_W-1:0] d_vec  [NUM_LANES];
    logic signed [OPND_W-1:0] ir_lat [NUM_LANES];
    logic signed [OPND_W-1:0] d_lat  [NUM_LANES];
    logic [MAC_W-1:0]         mac_q  [NUM_LANES];
    logic [OPND_W-1:0]        iro_q  [NUM_LANES];
    logic [NUM_LANES-1:0]     sat_q;
    logic                     err_q;
    logic                     sq_lat, sh_lat, lm_lat;

    logic             opc_ok, accept, lane_we, sum_we;
    logic [IDX_W-1:0] lane_idx, nxt_idx, prv_idx;

    logic signed [OPND_W-1:0] ir_a, d_a, ir_b, d_b, ir_self;
    logic signed [DIFF_W-1:0] full;
    logic [MAC_W-1:0]         mac_val;
    logic [OPND_W-1:0]        clamp_out;
    logic                     clamp_hit;

    // Gather the per-lane input ports into arrays.
    always_comb begin
        ir_vec[0] = ir_in1;
        ir_vec[1] = ir_in2;
        ir_vec[2] = ir_in3;
        d_vec[0]  = diag1;
        d_vec[1]  = diag2;
        d_vec[2]  = diag3;
        opc_ok    = (opcode == OPC_CROSS) || (opcode == OPC_SQUARE);
    end

    vop_ctrl #(.LANES(NUM_LANES), .IDX_W(IDX_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opc_ok   (opc_ok),
        .accept   (accept),
        .busy     (busy),
        .lane_we  (lane_we),
        .sum_we   (sum_we),
        .lane_idx (lane_idx),
        .done     (done)
    );

    // Capture the command modes in the accept cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_lat <= 1'b0;
            sh_lat <= 1'b0;
            lm_lat <= 1'b0;
        end else if (accept) begin
            sq_lat <= (opcode == OPC_SQUARE);
            sh_lat <= shift_sel;
            lm_lat <= lim_mode;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lat
        // Capture lane operands before any result overwrites the source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ir_lat[g] <= '0;
                d_lat[g]  <= '0;
            end else if (accept) begin
                ir_lat[g] <= ir_vec[g];
                d_lat[g]  <= d_vec[g];
            end
        end
    end

    // Rotate lane indices: lane n uses neighbours n+1 and n-1 (mod 3).
    always_comb begin
        nxt_idx = (lane_idx == IDX_W'(NUM_LANES - 1)) ? '0 : lane_idx + 1'b1;
        prv_idx = (lane_idx == '0) ? IDX_W'(NUM_LANES - 1) : lane_idx - 1'b1;
        ir_a    = ir_lat[prv_idx];
        d_a     = d_lat[nxt_idx];
        ir_b    = ir_lat[nxt_idx];
        d_b     = d_lat[prv_idx];
        ir_self = ir_lat[lane_idx];
    end

    vop_lane_math #(.W(OPND_W)) i_math (
        .sq      (sq_lat),
        .sh_en   (sh_lat),
        .ir_a    (ir_a),
        .d_a     (d_a),
        .ir_b    (ir_b),
        .d_b     (d_b),
        .ir_self (ir_self),
        .full    (full)
    );

    // Fit the exact lane value to the accumulator width.
    always_comb mac_val = MAC_W'(full);

    vop_clamp #(.IN_W(DIFF_W), .OUT_W(OPND_W)) i_clamp (
        .val (full),
        .lm  (lm_lat),
        .out (clamp_out),
        .hit (clamp_hit)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_res
        // Store accumulator, clamped copy and clamp flag for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mac_q[g] <= '0;
                iro_q[g] <= '0;
                sat_q[g] <= 1'b0;
            end else if (accept) begin
                sat_q[g] <= 1'b0;
            end else if (lane_we && (lane_idx == IDX_W'(g))) begin
                mac_q[g] <= mac_val;
                iro_q[g] <= clamp_out;
                sat_q[g] <= clamp_hit;
            end
        end
    end

    // Clear the summary bit on accept, recompute it after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (accept) err_q <= 1'b0;
        else if (sum_we) err_q <= |sat_q;
    end

    // Drive the result ports from the lane registers.
    always_comb begin
        mac1    = mac_q[0];
        mac2    = mac_q[1];
        mac3    = mac_q[2];
        ir_out1 = iro_q[0];
        ir_out2 = iro_q[1];
        ir_out3 = iro_q[2];
        flags   = {err_q, sat_q};
    end

    if (DIFF_W > MAC_W) begin : g_fit_chk
        assert_mac_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_we |-> ((&full[DIFF_W-1:MAC_W-1]) || !(|full[DIFF_W-1:MAC_W-1])));
    end
    assert_sat_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we && lm_lat) |-> !clamp_out[OPND_W-1]);
    assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (flags == 4'b0000));
    assert_err_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[3] == |flags[2:0]));
    assert_operands_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ir_lat[0]) && $stable(ir_lat[1]) && $stable(ir_lat[2])
                  && $stable(d_lat[0]) && $stable(d_lat[1]) && $stable(d_lat[2])));
endmodule

// File: tb/test_vop_unit.sv
module test_vop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic        shift_sel = 1'b0, lim_mode = 1'b0;
    logic [15:0] ir_in1 = '0, ir_in2 = '0, ir_in3 = '0;
    logic [15:0] diag1 = '0, diag2 = '0, diag3 = '0;
    logic        busy, done;
    logic [31:0] mac1, mac2, mac3;
    logic [15:0] ir_out1, ir_out2, ir_out3;
    logic [3:0]  flags;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    int     t_ir [3];
    int     t_d  [3];
    longint exp_mac [3];
    int     exp_ir  [3];
    bit     exp_sat [3];

    always #2 clk = ~clk;

    vop_unit i_vop_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .shift_sel(shift_sel), .lim_mode(lim_mode),
        .ir_in1(ir_in1), .ir_in2(ir_in2), .ir_in3(ir_in3),
        .diag1(diag1), .diag2(diag2), .diag3(diag3),
        .busy(busy), .done(done), .mac1(mac1), .mac2(mac2), .mac3(mac3),
        .ir_out1(ir_out1), .ir_out2(ir_out2), .ir_out3(ir_out3), .flags(flags)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint get_mac(input int n);
        return (n == 0) ? longint'($signed(mac1)) :
               (n == 1) ? longint'($signed(mac2)) : longint'($signed(mac3));
    endfunction

    function automatic int get_ir(input int n);
        return (n == 0) ? int'($signed(ir_out1)) :
               (n == 1) ? int'($signed(ir_out2)) : int'($signed(ir_out3));
    endfunction

    // Expected results from the requirement formulas.
    function automatic void model(input bit sq, input bit sh, input bit lm);
        for (int n = 0; n < 3; n++) begin
            int     p = (n + 2) % 3;
            int     q = (n + 1) % 3;
            longint v;
            int     lo;
            if (sq) v = longint'(t_ir[n]) * t_ir[n];
            else    v = longint'(t_ir[p]) * t_d[q] - longint'(t_ir[q]) * t_d[p];
            if (sh) v = v >>> 12;
            exp_mac[n] = v;
            lo = lm ? 0 : -32768;
            if (v > 32767)   begin exp_ir[n] = 32767; exp_sat[n] = 1'b1; end
            else if (v < lo) begin exp_ir[n] = lo;    exp_sat[n] = 1'b1; end
            else             begin exp_ir[n] = int'(v); exp_sat[n] = 1'b0; end
        end
    endfunction

    task automatic drive_operands();
        ir_in1 = 16'(t_ir[0]); ir_in2 = 16'(t_ir[1]); ir_in3 = 16'(t_ir[2]);
        diag1  = 16'(t_d[0]);  diag2  = 16'(t_d[1]);  diag3  = 16'(t_d[2]);
    endtask

    task automatic run_cmd(input bit sq, input bit sh, input bit lm, input bit disturb);
        int  cyc;
        logic [3:0] exp_flags;
        string rm, ri;
        model(sq, sh, lm);
        rm = sq ? "R4" : "R3";
        ri = lm ? "R6" : "R5";
        @(negedge clk);
        drive_operands();
        opcode = sq ? 6'h28 : 6'h0C; shift_sel = sh; lim_mode = lm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(busy == 1'b1, "R2", "busy after accept", longint'(busy), 1);
        check(flags == 4'b0, "R7", "flags cleared", longint'(flags), 0);
        if (disturb) begin
            ir_in1 = 16'($urandom); ir_in2 = 16'($urandom); ir_in3 = 16'($urandom);
            diag1 = 16'($urandom); diag2 = 16'($urandom); diag3 = 16'($urandom);
            shift_sel = ~sh; lim_mode = ~lm; opcode = sq ? 6'h0C : 6'h28;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc = 2;
        end
        while (!done && cyc < 12) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 5, "R2", "cycles to done", cyc, 5);
        check(busy == 1'b0, "R2", "busy low at done", longint'(busy), 0);
        for (int n = 0; n < 3; n++) begin
            check(get_mac(n) == exp_mac[n], disturb ? "R8" : rm, $sformatf("mac lane %0d", n + 1),
                  get_mac(n), exp_mac[n]);
            check(get_ir(n) == exp_ir[n], disturb ? "R8" : ri, $sformatf("ir lane %0d", n + 1),
                  get_ir(n), exp_ir[n]);
        end
        exp_flags = {exp_sat[0] | exp_sat[1] | exp_sat[2], exp_sat[2], exp_sat[1], exp_sat[0]};
        check(flags == exp_flags, "R7", "flags at done", longint'(flags), longint'(exp_flags));
        @(negedge clk);
        check(done == 1'b0, disturb ? "R9" : "R2", "done single cycle", longint'(done), 0);
    endtask

    task automatic bad_opcode();
        logic [31:0] m1;
        logic [15:0] o1;
        logic [3:0]  f;
        bit seen = 1'b0;
        m1 = mac1; o1 = ir_out1; f = flags;
        @(negedge clk);
        t_ir[0] = 1234; t_ir[1] = -77; t_ir[2] = 999;
        t_d[0] = 5; t_d[1] = 6; t_d[2] = 7;
        drive_operands();
        opcode = 6'h01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10", "busy after bad opcode", longint'(busy), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
        end
        check(!seen, "R10", "no activity", longint'(seen), 0);
        check(mac1 == m1 && ir_out1 == o1 && flags == f, "R10", "results kept",
              longint'(mac1), longint'(m1));
    endtask

    initial begin
        #(4 * 200000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && flags == 0, "R1", "control in reset",
              longint'({busy, done, flags}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mac1 == 0 && mac2 == 0 && mac3 == 0, "R1", "mac after reset",
              longint'(mac1 | mac2 | mac3), 0);
        check(ir_out1 == 0 && ir_out2 == 0 && ir_out3 == 0 && flags == 0 && !busy && !done,
              "R1", "ir and flags after reset", longint'(ir_out1 | ir_out2 | ir_out3), 0);

        // R3: small mixed signs, no scaling
        t_ir = '{100, -200, 300}; t_d = '{4096, -4096, 2048};
        run_cmd(1'b0, 1'b0, 1'b0, 1'b0);
        // R3/R5: full-scale operands, clamping both ways
        t_ir = '{-32768, -32768, -32768}; t_d = '{32767, -32768, 32767};
        run_cmd(1'b0, 1'b0, 1'b0, 1'b0);
        // R3: arithmetic shift of -1 stays -1
        t_ir = '{0, 1, 0}; t_d = '{0, 0, 1};
        run_cmd(1'b0, 1'b1, 1'b0, 1'b0);
        // R6: negative results clamp to zero
        t_ir = '{-32768, 32767, -1000}; t_d = '{-32768, 30000, 32767};
        run_cmd(1'b0, 1'b1, 1'b1, 1'b0);
        t_ir = '{-32768, 32767, -1000}; t_d = '{-32768, 30000, 32767};
        run_cmd(1'b0, 1'b0, 1'b1, 1'b0);
        // R4: squares of full scale and small values
        t_ir = '{-32768, 181, 0}; t_d = '{1, 2, 3};
        run_cmd(1'b1, 1'b0, 1'b0, 1'b0);
        t_ir = '{-32768, 4096, -1}; t_d = '{0, 0, 0};
        run_cmd(1'b1, 1'b1, 1'b1, 1'b0);
        // R7: a clean command after a clamping one leaves flags clear
        t_ir = '{3, 4, 5}; t_d = '{6, 7, 8};
        run_cmd(1'b0, 1'b0, 1'b0, 1'b0);
        // R8/R9: operands changed and start repeated while busy
        t_ir = '{-20000, 15000, 7}; t_d = '{12000, -9, 32767};
        run_cmd(1'b0, 1'b1, 1'b0, 1'b1);
        // R10: unsupported opcode
        bad_opcode();

        for (int k = 0; k < 60; k++) begin
            for (int n = 0; n < 3; n++) begin
                t_ir[n] = int'($signed(16'($urandom)));
                t_d[n]  = int'($signed(16'($urandom)));
            end
            run_cmd(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule